// File: doc/BRIEF.md
# Reset Cause Detector

This unit sits beside a small CPU core and watches its bus for conditions that should never happen in correct code. On every cycle it looks at an opcode-fetch qualifier, the bus address and the opcode byte being fetched. It combines what it finds with a watchdog timeout into one internal reset. It also watches the shared, active-low reset pin, so that it can tell a reset forced from outside apart from one it raised itself.

Several events count as internal causes: a watchdog timeout, an opcode outside the legal set, the stop opcode, and an opcode fetch from an address that lies in neither the RAM window nor the program-memory window. For any of them, the unit enables the pin pull-down for a fixed number of cycles. It also records the cause in a five-bit status word. Software reads that word after it restarts, and the read clears it. A plain data access to unmapped space is harmless. An address fault counts only when the CPU marks the access as an opcode fetch.

Top module: `rst_cause_unit`

## Requirements
- R1: While `por_n` is low, `sts` is 5'b10000 (power-on bit 4 only), `pin_drive` is 0 and the hold counter is cleared. Clearing is asynchronous.
- R2: When `wdog_to` is high and the unit is not driving the pin, the next edge sets `sts` to contain bit 2 and starts the pin drive.
- R3: An opcode fetch whose opcode is missing from the legal map sets bit 1 and starts the pin drive. In the default map, 0x32, 0x3B and 0x75 are the only entries marked illegal.
- R4: Opcode 0x8E (stop) on an opcode fetch is always treated as illegal and sets bit 1, whatever the legal map says.
- R5: An opcode fetch from outside both windows sets bit 0 and starts the pin drive. By default RAM is 0x0060–0x025F and program memory is 0x8000–0xFFFF, both bounds inclusive.
- R6: A cycle with `fetch` low causes no internal reset, whatever the address and opcode are.
- R7: `pin_drive` stays high for exactly 32 cycles after an internal cause. New causes and pin activity are ignored while it is high.
- R8: When the unit is not driving and `pin_n` is low with no internal cause present, `sts` becomes 5'b01000 (pin bit 3 only). An internal cause in the same cycle takes priority over the pin.
- R9: A new cause replaces the whole status word with the bits of the causes present in that cycle. `sts_rd` clears `sts` to 0 at the next edge unless an event in that same cycle writes it.
- R10: `rst_n` is low whenever `pin_drive` is high or `pin_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| pin_n | input | 1 | Sensed level of the shared reset pin |
| fetch | input | 1 | High when the current bus access is an opcode fetch |
| addr | input | ADDR_W | Bus address |
| opcode | input | 8 | Opcode byte on the bus |
| wdog_to | input | 1 | Watchdog timeout pulse |
| sts_rd | input | 1 | Status read strobe; clears the status word |
| sts | output | 5 | Status: 4 power-on, 3 pin, 2 watchdog, 1 opcode, 0 address |
| pin_drive | output | 1 | Enable for the reset-pin pull-down |
| rst_n | output | 1 | Internal reset to the rest of the chip, active low |

## Verification
The bench fetches at each edge of both memory windows and at the addresses just outside them. A design with a range off by one would reset on a legal fetch, or would let a stray fetch run on. The bench also issues causes and pin pulses during a hold, and checks that the pull-down lasts exactly 32 cycles. A design that re-armed early would stretch or retrigger the reset. Finally, it lines up status reads with new causes in the same cycle, so a design that let the read win would lose the reason for the reset.

// File: rtl/rst_cause_unit.sv
module rst_cause_unit #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] RAM_LO = 16'h0060,
  parameter logic [ADDR_W-1:0] RAM_HI = 16'h025F,
  parameter logic [ADDR_W-1:0] ROM_LO = 16'h8000,
  parameter logic [ADDR_W-1:0] ROM_HI = 16'hFFFF,
  parameter logic [7:0] STOP_OP = 8'h8E,
  parameter logic [255:0] LEGAL_MAP = ~((256'd1 << 8'h32) | (256'd1 << 8'h3B) | (256'd1 << 8'h75)),
  parameter int HOLD_CYC = 32
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              pin_n,
  input  logic              fetch,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        opcode,
  input  logic              wdog_to,
  input  logic              sts_rd,
  output logic [4:0]        sts,
  output logic              pin_drive,
  output logic              rst_n
);
  localparam int CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] HOLD_V = CW'(HOLD_CYC);
  localparam logic [ADDR_W-1:0] RAM_SPAN = RAM_HI - RAM_LO;
  localparam logic [ADDR_W-1:0] ROM_SPAN = ROM_HI - ROM_LO;

  logic [CW-1:0]     cnt;
  logic [ADDR_W-1:0] ram_off, rom_off;
  logic              mapped, opc_bad, armed;
  logic              wd_hit, op_hit, ad_hit, int_hit, ext_hit;

  assign ram_off = addr - RAM_LO;
  assign rom_off = addr - ROM_LO;
  assign mapped  = (ram_off <= RAM_SPAN) || (rom_off <= ROM_SPAN);
  assign opc_bad = !LEGAL_MAP[opcode] || (opcode == STOP_OP);

  assign armed   = (cnt == '0);
  assign wd_hit  = armed && wdog_to;
  assign op_hit  = armed && fetch && opc_bad;
  assign ad_hit  = armed && fetch && !mapped;
  assign int_hit = wd_hit || op_hit || ad_hit;
  assign ext_hit = armed && !pin_n && !int_hit;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      sts <= 5'b10000;
      cnt <= '0;
    end else if (int_hit) begin
      sts <= {2'b00, wd_hit, op_hit, ad_hit};
      cnt <= HOLD_V;
    end else begin
      if (!armed) cnt <= cnt - 1'b1;
      if (ext_hit)     sts <= 5'b01000;
      else if (sts_rd) sts <= '0;
    end
  end

  assign pin_drive = !armed;
  assign rst_n     = pin_n && !pin_drive;
endmodule

module rst_cause_chk #(
  parameter int HOLD_CYC = 32
) (
  input logic       clk,
  input logic       por_n,
  input logic       pin_n,
  input logic       fetch,
  input logic       wdog_to,
  input logic       sts_rd,
  input logic [4:0] sts,
  input logic       pin_drive,
  input logic       rst_n
);
  logic [15:0] run;
  always_ff @(posedge clk or negedge por_n)
    if (!por_n) run <= '0;
    else        run <= pin_drive ? run + 16'd1 : 16'd0;

  // R2
  wdog_sets_chk: assert property (@(posedge clk) disable iff (!por_n)
    (wdog_to && !pin_drive) |=> (pin_drive && sts[2]));

  // R6
  data_quiet_chk: assert property (@(posedge clk) disable iff (!por_n)
    (!pin_drive && !wdog_to && !fetch) |=> !pin_drive);

  // R7
  hold_len_chk: assert property (@(posedge clk) disable iff (!por_n)
    $fell(pin_drive) |-> (run == 16'(HOLD_CYC)));

  // R7
  hold_max_chk: assert property (@(posedge clk) disable iff (!por_n)
    run <= 16'(HOLD_CYC));

  // R8
  pin_only_chk: assert property (@(posedge clk) disable iff (!por_n)
    (!pin_drive && !pin_n && !wdog_to && !fetch) |=> (sts == 5'b01000));

  // R9
  read_clr_chk: assert property (@(posedge clk) disable iff (!por_n)
    (sts_rd && pin_n && !wdog_to && !fetch) |=> (sts == 5'b00000));

  // R10
  always_comb if (por_n && (pin_drive || !pin_n)) rst_out_chk: assert (!rst_n);
endmodule

bind rst_cause_unit rst_cause_chk #(.HOLD_CYC(HOLD_CYC)) u_chk (.*);

// File: tb/rst_cause_unit_test.sv
module rst_cause_unit_test;
  logic clk = 0, por_n = 0, pin_n = 1, fetch = 0, wdog_to = 0, sts_rd = 0;
  logic [15:0] addr = 16'h8000;
  logic [7:0]  opcode = 8'h00;
  logic [4:0]  sts;
  logic        pin_drive, rst_n;

  int checks = 0, fails = 0, cyc = 0;
  logic [4:0] m_sts = 5'b10000;
  int m_cnt = 0;

  always #4 clk = ~clk;

  rst_cause_unit uut (.clk, .por_n, .pin_n, .fetch, .addr, .opcode,
                      .wdog_to, .sts_rd, .sts, .pin_drive, .rst_n);

  function automatic bit is_mapped(input logic [15:0] a);
    return (a >= 16'h0060 && a <= 16'h025F) || (a >= 16'h8000);
  endfunction

  function automatic bit is_bad(input logic [7:0] o);
    return o == 8'h32 || o == 8'h3B || o == 8'h75 || o == 8'h8E;
  endfunction

  task automatic cmp(input string tag);
    checks++;
    if (sts !== m_sts || pin_drive !== (m_cnt != 0) || rst_n !== (pin_n && m_cnt == 0)) begin
      fails++;
      $display("FAIL %s: sts=%b drive=%b rst_n=%b expected sts=%b drive=%b rst_n=%b",
               tag, sts, pin_drive, rst_n, m_sts, m_cnt != 0, pin_n && m_cnt == 0);
    end
  endtask

  task automatic step(input bit wd, input bit f, input logic [15:0] a,
                      input logic [7:0] o, input bit pn, input bit rd);
    bit armed, iw, io, ia, ext;
    string tag;
    wdog_to = wd; fetch = f; addr = a; opcode = o; pin_n = pn; sts_rd = rd;
    armed = (m_cnt == 0);
    iw = armed && wd;
    io = armed && f && is_bad(o);
    ia = armed && f && !is_mapped(a);
    ext = armed && !pn && !(iw || io || ia);
    if (!armed) tag = "R7";
    else if (iw) tag = "R2";
    else if (io) tag = (o == 8'h8E) ? "R4" : "R3";
    else if (ia) tag = "R5";
    else if (ext) tag = "R8";
    else if (rd) tag = "R9";
    else tag = "R6/R10";
    if (iw || io || ia) begin
      m_sts = {2'b00, iw, io, ia};
      m_cnt = 32;
    end else begin
      if (m_cnt != 0) m_cnt--;
      if (ext) m_sts = 5'b01000;
      else if (rd) m_sts = 5'b00000;
    end
    @(posedge clk);
    @(negedge clk);
    cmp(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 16'h0000, 8'h00, 1, 0);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: run did not end, expected completion");
      summary();
    end
  end

  initial begin
    logic [15:0] edges [8];
    void'($urandom(32'h5EED_1234));
    edges = '{16'h005F, 16'h0060, 16'h025F, 16'h0260, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h0000};
    repeat (3) @(negedge clk);
    cmp("R1");
    por_n = 1;
    idle(2);
    // R9 read clears power-on status
    step(0, 0, 16'h0000, 8'h00, 1, 1);
    // R5 boundaries of both windows
    foreach (edges[i]) begin
      step(0, 1, edges[i], 8'hA6, 1, 0);
      idle(34);
    end
    // R4 stop opcode at a mapped address
    step(0, 1, 16'h9000, 8'h8E, 1, 0);
    idle(34);
    // R3 illegal opcode from the map
    step(0, 1, 16'h0100, 8'h32, 1, 0);
    // R7 causes and pin ignored during hold
    step(1, 1, 16'h4000, 8'h75, 0, 0);
    idle(33);
    // R6 data access to unmapped space with bad opcode
    step(0, 0, 16'h4000, 8'h3B, 1, 0);
    // R9 read together with watchdog: cause wins
    step(1, 0, 16'h0000, 8'h00, 1, 1);
    idle(34);
    // R8 pin reset, then internal wins over pin
    step(0, 0, 16'h0000, 8'h00, 0, 0);
    step(0, 1, 16'h0300, 8'h00, 0, 0);
    idle(34);
    // R1 power-on in the middle of a hold
    step(1, 0, 16'h0000, 8'h00, 1, 0);
    @(negedge clk) por_n = 0;
    m_sts = 5'b10000; m_cnt = 0;
    #1 cmp("R1");
    @(negedge clk) por_n = 1;
    for (int i = 0; i < 6000; i++) begin
      bit wd, f, pn, rd;
      logic [15:0] a;
      logic [7:0] o;
      wd = ($urandom_range(0, 59) == 0);
      f  = ($urandom_range(0, 1) == 1);
      pn = ($urandom_range(0, 49) != 0);
      rd = ($urandom_range(0, 7) == 0);
      a  = ($urandom_range(0, 3) == 0) ? edges[$urandom_range(0, 7)] : 16'($urandom);
      if ($urandom_range(0, 3) != 0 && f) a = 16'h8000 | 16'($urandom);
      o  = 8'($urandom);
      step(wd, f, a, o, pn, rd);
    end
    summary();
  end
endmodule